// File: doc/BRIEF.md
# Serial Display Command and Data Writer

This block is a transmit-only serial engine for a small display controller. A host posts one request at a time on a simple valid-plus-opcode interface. The block then drives four display lines: an active-low select, a register-select line that marks each byte as a command or as pixel/parameter data, a serial clock, and a serial data line. Bits leave most significant first. The display latches data on each rising clock edge. It latches the register-select line on the rising edge of the last clock of each byte.

Three transactions are supported. The first is a lone command byte. The second is a command byte followed by one data byte, both under a single select window. The third is a data burst pulled byte by byte from a valid/ready stream, with the select held low from the first byte to the byte flagged as last. Two parameters set the rest: the length of each serial clock phase, in system clocks, and the byte width.

Top module: `serdisp_writer`

## Requirements
- R1: While `dsp_cs_n` is high, `dsp_dc`, `dsp_sck` and `dsp_sd` are all high; this is also the state held during and after reset.
- R2: Each byte is sent most significant bit first, one bit per rising edge of `dsp_sck` inside a select window, and a window never closes in the middle of a byte.
- R3: `dsp_sd` changes only while `dsp_sck` is low; it holds its value through every high phase.
- R4: `dsp_dc` is 0 for a command byte and 1 for a data byte, and is constant through the high phases of that byte.
- R5: A transaction opens with `dsp_cs_n` falling while `dsp_sck` is low and `dsp_sd` is high; this preset lasts `HALF_CYC` clocks before the first bit is placed.
- R6: Every `dsp_sck` phase lasts at least `HALF_CYC` clocks. With no stream stall, every low phase lasts exactly `HALF_CYC` clocks, except the first one of a window, which includes the preset and lasts 2*`HALF_CYC`.
- R7: `req_op` is sampled with `req_valid`. 2'b00 sends `req_cmd` alone. 2'b01 sends `req_cmd` and then `req_data` in one select window. 2'b10 starts a stream burst. 2'b11 starts nothing.
- R8: In a burst, `dsp_cs_n` stays low and `dsp_dc` stays 1 across all bytes. The burst ends after the byte marked by `s_last`. `s_ready` is high for exactly one cycle per byte, only together with `s_valid`, in the cycle that byte is taken.
- R9: `busy` rises in the cycle after a request is accepted and is high exactly while `dsp_cs_n` is low.
- R10: A request presented while `busy` is high is ignored and produces no further bytes or windows.
- R11: Asserting `rst_n` low returns all four lines to idle-high and `busy` to 0 at once, and discards a partly sent byte; the next request transmits cleanly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_op | input | 2 | Transaction kind (see R7) |
| req_cmd | input | BYTE_W | Command byte |
| req_data | input | BYTE_W | Data byte for the command-plus-data kind |
| busy | output | 1 | High while a transaction is in progress |
| s_valid | input | 1 | Burst stream byte available |
| s_data | input | BYTE_W | Burst stream byte |
| s_last | input | 1 | Marks the final byte of a burst |
| s_ready | output | 1 | Burst stream byte taken this cycle |
| dsp_cs_n | output | 1 | Display select, active low |
| dsp_dc | output | 1 | Register select: 0 command, 1 data |
| dsp_sck | output | 1 | Serial clock, idle high |
| dsp_sd | output | 1 | Serial data, idle high |

## Verification
The bench builds the block with `HALF_CYC` = 2 and `BYTE_W` = 8. Under these values, each byte takes about 34 cycles. That keeps a full sweep of all 256 command values, and of 256 command/data pairs, well within the run length. The two-clock phase still exercises the phase counter rather than the single-clock shortcut. A line-level decoder in the bench rebuilds bytes from the rising edges and times every clock phase exactly. Short bursts, with and without stream gaps and with a late first byte, reach the stall paths, while the last-byte flag is swept from one to sixteen bytes.

// File: rtl/serdisp_pkg.sv
package serdisp_pkg;

   // Request kinds; the code values are part of the host interface.
   typedef enum logic [1:0] {
      OP_CMD      = 2'b00,
      OP_CMD_DATA = 2'b01,
      OP_BURST    = 2'b10,
      OP_NONE     = 2'b11
   } sd_op_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_SETUP,
      ST_LOW,
      ST_HIGH
   } sd_state_e;

endpackage

// File: rtl/serdisp_phase_timer.sv
module serdisp_phase_timer #(
   parameter int HALF_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic done
);

   generate
      if (HALF_CYC < 1) begin : g_bad_half
         $error("serdisp_phase_timer: HALF_CYC must be at least 1");
      end

      if (HALF_CYC == 1) begin : g_direct
         // Every phase is one clock long: the phase ends on its first cycle.
         assign done = 1'b1;
      end else begin : g_count
         localparam int CW = $clog2(HALF_CYC);
         localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (restart) begin
               cnt_q <= '0;
            end else if (cnt_q != LAST) begin
               cnt_q <= cnt_q + 1'b1;
            end
         end

         assign done = (cnt_q == LAST);

         // R6: the phase count never runs past the configured length
         a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_q <= LAST);
      end
   endgenerate

endmodule

// File: rtl/serdisp_byte_shift.sv
module serdisp_byte_shift #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [BYTE_W-1:0] load_val,
   input  logic              shift,
   output logic              msb,
   output logic              last_bit
);

   localparam int IW = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
   localparam logic [IW-1:0] TOP_IDX = IW'(BYTE_W - 1);

   logic [BYTE_W-1:0] sh_q;
   logic [IW-1:0]     idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q  <= '0;
         idx_q <= '0;
      end else if (load) begin
         sh_q  <= load_val;
         idx_q <= TOP_IDX;
      end else if (shift) begin
         sh_q  <= {sh_q[BYTE_W-2:0], 1'b0};
         idx_q <= idx_q - 1'b1;
      end
   end

   assign msb      = sh_q[BYTE_W-1];
   assign last_bit = (idx_q == '0);

   // R2: a byte never shifts past its final bit
   a_r2_no_overshift: assert property (@(posedge clk) disable iff (!rst_n)
      (shift && !load) |-> !last_bit);

   // R2: after a load the first bit on the line is the top bit of the value
   a_r2_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (msb == $past(load_val[BYTE_W-1])));

endmodule

// File: rtl/serdisp_writer.sv
module serdisp_writer #(
   parameter int HALF_CYC = 4,
   parameter int BYTE_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_op,
   input  logic [BYTE_W-1:0] req_cmd,
   input  logic [BYTE_W-1:0] req_data,
   output logic              busy,
   input  logic              s_valid,
   input  logic [BYTE_W-1:0] s_data,
   input  logic              s_last,
   output logic              s_ready,
   output logic              dsp_cs_n,
   output logic              dsp_dc,
   output logic              dsp_sck,
   output logic              dsp_sd
);
   import serdisp_pkg::*;

   generate
      if (BYTE_W < 2) begin : g_bad_width
         $error("serdisp_writer: BYTE_W must be at least 2");
      end
      if (HALF_CYC < 1) begin : g_bad_half
         $error("serdisp_writer: HALF_CYC must be at least 1");
      end
   endgenerate

   sd_state_e         state_q, state_d;
   logic              dc_q, dc_d;
   logic              pend_q, pend_d;     // data byte still owed after the command
   logic              burst_q, burst_d;
   logic              last_q, last_d;     // current burst byte is the final one
   logic [BYTE_W-1:0] hold_q, hold_d;

   logic              restart;
   logic              phase_done;
   logic              sh_load, sh_shift;
   logic [BYTE_W-1:0] sh_val;
   logic              sh_msb, sh_last;
   logic              take;
   sd_op_e            op;

   assign op = sd_op_e'(req_op);

   serdisp_phase_timer #(.HALF_CYC(HALF_CYC)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart),
      .done    (phase_done)
   );

   serdisp_byte_shift #(.BYTE_W(BYTE_W)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (sh_load),
      .load_val (sh_val),
      .shift    (sh_shift),
      .msb      (sh_msb),
      .last_bit (sh_last)
   );

   always_comb begin
      state_d  = state_q;
      dc_d     = dc_q;
      pend_d   = pend_q;
      burst_d  = burst_q;
      last_d   = last_q;
      hold_d   = hold_q;
      restart  = 1'b0;
      sh_load  = 1'b0;
      sh_shift = 1'b0;
      sh_val   = req_cmd;
      take     = 1'b0;

      unique case (state_q)
         ST_IDLE: begin
            if (req_valid && op != OP_NONE) begin
               state_d = ST_SETUP;
               restart = 1'b1;
               burst_d = (op == OP_BURST);
               dc_d    = (op == OP_BURST);
               pend_d  = (op == OP_CMD_DATA);
               hold_d  = req_data;
               last_d  = 1'b1;
               if (op != OP_BURST) begin
                  sh_load = 1'b1;
                  sh_val  = req_cmd;
               end
            end
         end

         ST_SETUP: begin
            if (phase_done) begin
               if (!burst_q) begin
                  state_d = ST_LOW;
                  restart = 1'b1;
               end else if (s_valid) begin
                  take    = 1'b1;
                  sh_load = 1'b1;
                  sh_val  = s_data;
                  last_d  = s_last;
                  state_d = ST_LOW;
                  restart = 1'b1;
               end
            end
         end

         ST_LOW: begin
            if (phase_done) begin
               state_d = ST_HIGH;
               restart = 1'b1;
            end
         end

         ST_HIGH: begin
            if (phase_done) begin
               if (!sh_last) begin
                  sh_shift = 1'b1;
                  state_d  = ST_LOW;
                  restart  = 1'b1;
               end else if (pend_q) begin
                  sh_load = 1'b1;
                  sh_val  = hold_q;
                  dc_d    = 1'b1;
                  pend_d  = 1'b0;
                  state_d = ST_LOW;
                  restart = 1'b1;
               end else if (burst_q && !last_q) begin
                  if (s_valid) begin
                     take    = 1'b1;
                     sh_load = 1'b1;
                     sh_val  = s_data;
                     last_d  = s_last;
                     state_d = ST_LOW;
                     restart = 1'b1;
                  end
               end else begin
                  state_d = ST_IDLE;
                  restart = 1'b1;
               end
            end
         end

         default: begin
            state_d = ST_IDLE;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         dc_q    <= 1'b1;
         pend_q  <= 1'b0;
         burst_q <= 1'b0;
         last_q  <= 1'b1;
         hold_q  <= '0;
      end else begin
         state_q <= state_d;
         dc_q    <= dc_d;
         pend_q  <= pend_d;
         burst_q <= burst_d;
         last_q  <= last_d;
         hold_q  <= hold_d;
      end
   end

   assign busy     = (state_q != ST_IDLE);
   assign s_ready  = take;
   assign dsp_cs_n = (state_q == ST_IDLE);
   assign dsp_dc   = (state_q == ST_IDLE) ? 1'b1 : dc_q;
   assign dsp_sck  = (state_q == ST_IDLE) || (state_q == ST_HIGH);
   assign dsp_sd   = (state_q == ST_IDLE) || (state_q == ST_SETUP) ? 1'b1 : sh_msb;

   // ---------------- checks ----------------
   localparam int RW = $clog2(HALF_CYC + 1) + 1;
   localparam logic [RW-1:0] RUN_MAX = {RW{1'b1}};
   localparam logic [RW-1:0] RUN_MIN = RW'(HALF_CYC);

   logic          sck_prev_q;
   logic [RW-1:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_prev_q <= 1'b1;
         run_q      <= '0;
      end else begin
         sck_prev_q <= dsp_sck;
         if (dsp_sck != sck_prev_q) begin
            run_q <= RW'(1);
         end else if (run_q != RUN_MAX) begin
            run_q <= run_q + 1'b1;
         end
      end
   end

   a_r1_idle_lines: assert property (@(posedge clk) disable iff (!rst_n)
      dsp_cs_n |-> (dsp_dc && dsp_sck && dsp_sd));

   a_r3_sd_held_high: assert property (@(posedge clk) disable iff (!rst_n)
      (!dsp_cs_n && !$past(dsp_cs_n) && dsp_sck && $past(dsp_sck)) |-> $stable(dsp_sd));

   a_r4_dc_held_high: assert property (@(posedge clk) disable iff (!rst_n)
      (!dsp_cs_n && !$past(dsp_cs_n) && dsp_sck && $past(dsp_sck)) |-> $stable(dsp_dc));

   a_r5_start_preset: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dsp_cs_n) |-> (!dsp_sck && dsp_sd));

   a_r6_phase_min: assert property (@(posedge clk) disable iff (!rst_n)
      ((dsp_sck != sck_prev_q) && !$past(dsp_cs_n)) |-> (run_q >= RUN_MIN));

   a_r8_ready_in_window: assert property (@(posedge clk) disable iff (!rst_n)
      s_ready |-> (s_valid && !dsp_cs_n && dsp_dc));

   a_r9_busy_window: assert property (@(posedge clk) disable iff (!rst_n)
      busy == !dsp_cs_n);

   a_r9_busy_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(req_valid));

endmodule

// File: tb/serdisp_writer_test.sv
`timescale 1ns/1ps
module serdisp_writer_test;

   localparam int H = 2;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         req_valid = 1'b0;
   logic [1:0]   req_op = 2'b00;
   logic [W-1:0] req_cmd = '0;
   logic [W-1:0] req_data = '0;
   logic         busy;
   logic         s_valid = 1'b0;
   logic [W-1:0] s_data = '0;
   logic         s_last = 1'b0;
   logic         s_ready;
   logic         cs_n, dc, sck, sd;

   always #5 clk = ~clk;

   serdisp_writer #(.HALF_CYC(H), .BYTE_W(W)) uut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_op(req_op), .req_cmd(req_cmd), .req_data(req_data),
      .busy(busy),
      .s_valid(s_valid), .s_data(s_data), .s_last(s_last), .s_ready(s_ready),
      .dsp_cs_n(cs_n), .dsp_dc(dc), .dsp_sck(sck), .dsp_sd(sd)
   );

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // expected byte stream
   logic [W-1:0] exp_val [0:1023];
   bit           exp_dc  [0:1023];
   int exp_wr = 0;
   int exp_rd = 0;
   int exp_win = 0;
   bit allow_stall = 1'b0;

   task automatic push(input logic [W-1:0] v, input bit d);
      exp_val[exp_wr] = v;
      exp_dc[exp_wr]  = d;
      exp_wr++;
   endtask

   // line-level monitor
   int bitcnt = 0, run = 0, win_bytes = 0, falls = 0, ready_cnt = 0;
   logic [W-1:0] shv = '0;
   bit prev_cs = 1'b1, prev_sck = 1'b1, first_low = 1'b0, sd_rise = 1'b0, dc_rise = 1'b0;

   always @(negedge clk) begin
      if (!rst_n) begin
         bitcnt = 0; win_bytes = 0; exp_rd = exp_wr;
         prev_cs = 1'b1; prev_sck = 1'b1;
      end else begin
         if (s_ready) begin
            ready_cnt++;
            chk(s_valid, "R8 ready without valid", 0, 1);
         end
         if (cs_n) begin
            chk(dc && sck && sd, "R1 idle lines", {dc, sck, sd}, 7);
            chk(!busy, "R9 busy outside window", busy, 0);
            if (!prev_cs) begin
               chk(bitcnt == 0, "R2 window closed mid-byte", bitcnt, 0);
               chk(win_bytes == exp_win, "R7/R8 bytes per window", win_bytes, exp_win);
            end
         end else begin
            chk(busy, "R9 busy inside window", busy, 1);
            if (prev_cs) begin
               chk(!sck && sd, "R5 start preset", {sck, sd}, 1);
               run = 1; first_low = 1'b1; win_bytes = 0; bitcnt = 0; falls++;
            end else if (sck != prev_sck) begin
               if (prev_sck) begin
                  chk(run >= H, "R6 high phase", run, H);
               end else begin
                  if (first_low)
                     chk(allow_stall ? run >= 2*H : run == 2*H, "R6 first low phase", run, 2*H);
                  else
                     chk(run == H, "R6 low phase", run, H);
                  first_low = 1'b0;
               end
               run = 1;
               if (sck) begin
                  sd_rise = sd; dc_rise = dc;
                  shv = {shv[W-2:0], sd};
                  bitcnt++;
                  if (bitcnt == W) begin
                     chk(exp_rd < exp_wr, "R2 unexpected byte", exp_rd, exp_wr);
                     if (exp_rd < exp_wr) begin
                        chk(shv == exp_val[exp_rd], "R2 byte value", shv, exp_val[exp_rd]);
                        chk(dc == exp_dc[exp_rd], "R4 register select", dc, exp_dc[exp_rd]);
                     end
                     exp_rd++; win_bytes++; bitcnt = 0;
                  end
               end
            end else begin
               run++;
               if (sck) begin
                  chk(sd == sd_rise, "R3 data moved while clock high", sd, sd_rise);
                  chk(dc == dc_rise, "R4 select moved while clock high", dc, dc_rise);
               end
            end
         end
         prev_cs = cs_n; prev_sck = sck;
      end
   end

   // byte stream source
   logic [W-1:0] st_mem [0:63];
   int st_len = 0, st_idx = 0, st_gap = 0, gap_cnt = 0;
   bit hs_pend = 1'b0;

   task automatic present();
      s_valid = 1'b1;
      s_data  = st_mem[st_idx];
      s_last  = (st_idx == st_len - 1);
   endtask

   always @(negedge clk) hs_pend = s_valid && s_ready;

   always @(posedge clk) begin
      if (hs_pend) begin
         #1;
         st_idx++;
         if (st_idx >= st_len) begin
            s_valid = 1'b0; s_last = 1'b0;
         end else if (st_gap > 0) begin
            s_valid = 1'b0; gap_cnt = st_gap;
         end else begin
            present();
         end
      end else if (gap_cnt > 0) begin
         #1;
         gap_cnt--;
         if (gap_cnt == 0) present();
      end
   end

   task automatic do_req(input logic [1:0] op, input logic [W-1:0] c, input logic [W-1:0] d);
      while (busy) @(negedge clk);
      @(posedge clk); #1;
      req_valid = 1'b1; req_op = op; req_cmd = c; req_data = d;
      @(posedge clk); #1;
      req_valid = 1'b0;
      @(negedge clk);
      if (op == 2'b11) chk(!busy, "R7 opcode 11 starts nothing", busy, 0);
      else             chk(busy, "R9 busy after accept", busy, 1);
   endtask

   task automatic wait_done();
      while (busy) @(negedge clk);
      repeat (3) @(negedge clk);
      chk(exp_rd == exp_wr, "R2 all expected bytes sent", exp_rd, exp_wr);
   endtask

   task automatic burst(input int len, input int gap, input int delay);
      st_len = len; st_idx = 0; st_gap = gap; gap_cnt = 0; ready_cnt = 0;
      for (int i = 0; i < len; i++) begin
         st_mem[i] = W'((len * 41 + i * 23 + 5) & 8'hFF);
         push(st_mem[i], 1'b1);
      end
      exp_win = len;
      allow_stall = (delay > 0);
      if (delay == 0) present();
      do_req(2'b10, 8'h00, 8'h00);
      if (delay > 0) begin
         repeat (delay) @(posedge clk);
         #1; present();
      end
      wait_done();
      chk(ready_cnt == len, "R8 one ready per byte", ready_cnt, len);
      chk(st_idx == len, "R8 stream fully consumed", st_idx, len);
      allow_stall = 1'b0;
   endtask

   // watchdog
   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int f0;
      #2;
      chk(cs_n && dc && sck && sd, "R11 lines idle in reset", {cs_n, dc, sck, sd}, 15);
      chk(!busy && !s_ready, "R11 busy/ready low in reset", {busy, s_ready}, 0);
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk(cs_n && dc && sck && sd, "R1 lines idle after reset", {cs_n, dc, sck, sd}, 15);

      // R7 single command, every value
      for (int v = 0; v < 256; v++) begin
         push(W'(v), 1'b0); exp_win = 1;
         do_req(2'b00, W'(v), W'(255 - v));
         wait_done();
      end

      // R7 command then data in one window
      for (int v = 0; v < 256; v++) begin
         push(W'(v), 1'b0); push(W'((v * 29 + 7) & 255), 1'b1); exp_win = 2;
         do_req(2'b01, W'(v), W'((v * 29 + 7) & 255));
         wait_done();
      end

      // R7 opcode 11 does nothing
      f0 = falls;
      for (int k = 0; k < 3; k++) do_req(2'b11, 8'h5A, 8'hA5);
      repeat (40) @(negedge clk);
      chk(falls == f0, "R7 opcode 11 opened a window", falls, f0);

      // R8 bursts
      burst(1, 0, 0);
      burst(2, 0, 0);
      burst(5, 0, 0);
      burst(16, 0, 0);
      burst(4, 3, 0);
      burst(3, 0, 10);

      // R10 requests while busy are ignored
      f0 = falls;
      push(8'h3C, 1'b0); exp_win = 1;
      do_req(2'b00, 8'h3C, 8'h00);
      repeat (6) @(posedge clk);
      #1 req_valid = 1'b1; req_op = 2'b01; req_cmd = 8'hFF; req_data = 8'h11;
      @(posedge clk); #1 req_op = 2'b10;
      @(posedge clk); #1 req_valid = 1'b0;
      wait_done();
      repeat (40) @(negedge clk);
      chk(falls == f0 + 1, "R10 extra window from ignored request", falls, f0 + 1);

      // R11 reset mid-byte
      push(8'hC3, 1'b0); exp_win = 1;
      do_req(2'b00, 8'hC3, 8'h00);
      repeat (12) @(posedge clk);
      #1 rst_n = 1'b0;
      #1;
      chk(cs_n && dc && sck && sd, "R11 lines idle on reset", {cs_n, dc, sck, sd}, 15);
      chk(!busy, "R11 busy cleared on reset", busy, 0);
      repeat (2) @(posedge clk);
      #1 rst_n = 1'b1;
      push(8'hA5, 1'b0); exp_win = 1;
      do_req(2'b00, 8'hA5, 8'h00);
      wait_done();
      chk(cs_n && !busy, "R11 clean transfer after reset", {cs_n, busy}, 2);

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule